// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two IEEE-754 values and returns the four condition flags N, Z, C and V that describe how they are ordered. It also reports an invalid-operation event and an input-denormal event. One input chooses between single precision (32 bits) and double precision (64 bits). A double-precision operand arrives as a pair of 32-bit words. A strobe starts each compare, and the flags appear in registers on the next clock edge. They then hold their values until the next strobe.

Three control inputs pick the variant. The first chooses a quiet or a signalling compare. The second replaces the second operand with +0.0. The third flushes denormal inputs to zero before the compare. The invalid-operation result is also gathered into a sticky flag. Only an explicit clear input resets the sticky flag.

A small controller has two states. ST_IDLE means no new result was produced on the last edge. ST_SHOW means the flags were just updated. The transitions are: ST_IDLE to ST_SHOW on a strobe, ST_SHOW to ST_SHOW on a back-to-back strobe, ST_SHOW to ST_IDLE when no strobe arrives, and ST_IDLE to ST_IDLE otherwise. `out_valid` is high exactly in ST_SHOW.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: When the operands are equal, the flags {N,Z,C,V} become 4'b0110.
- R2: When operand A is less than operand B, the flags become 4'b1000.
- R3: When operand A is greater than operand B, the flags become 4'b0010.
- R4: When at least one operand is a NaN (all-ones exponent, non-zero fraction), the result is unordered and the flags become 4'b0011.
- R5: In a quiet compare (`signal_cmp`=0), `inv_now` is 1 only when an operand is a signalling NaN. A NaN is signalling when the top fraction bit is 0 (bit 22 for single, bit 51 for double).
- R6: In a signalling compare (`signal_cmp`=1), `inv_now` is 1 for every unordered result.
- R7: With `cmp_zero`=1, operand B is replaced by +0.0, and `b_lo` and `b_hi` have no effect.
- R8: With `ftz_en`=1, a denormal input (zero exponent, non-zero fraction) compares as zero. With `ftz_en`=0, a denormal input compares by its true value.
- R9: +0 and -0 compare as equal.
- R10: With `use_double`=1, each operand is {hi,lo}, and the hi word supplies bits 63:32. With `use_double`=0, only the lo words are used and the hi words have no effect.
- R11: `inv_sticky` ORs in every `inv_now` result, and only `inv_clr` resets it. When a clear and a new invalid compare occur in the same cycle, the sticky flag ends up set.
- R12: Reset clears every output. The outputs update on the first rising edge after a cycle with `in_valid`=1, and `out_valid` is high for that one cycle. Without a strobe, the flags, `inv_now` and `dnm_now` hold their values.
- R13: `dnm_now` is 1 when `ftz_en`=1 and an operand actually used in the compare is denormal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compare strobe |
| use_double | input | 1 | 1 selects double precision, 0 selects single |
| cmp_zero | input | 1 | Compare operand A against +0.0 |
| signal_cmp | input | 1 | 1 selects a signalling compare, 0 a quiet compare |
| ftz_en | input | 1 | Flush denormal inputs to zero |
| a_lo | input | 32 | Operand A, low word |
| a_hi | input | 32 | Operand A, high word (double only) |
| b_lo | input | 32 | Operand B, low word |
| b_hi | input | 32 | Operand B, high word (double only) |
| inv_clr | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Flags were updated on this edge |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow (unordered) flag |
| inv_now | output | 1 | Invalid operation in the last compare |
| inv_sticky | output | 1 | Accumulated invalid operation |
| dnm_now | output | 1 | Input denormal flushed in the last compare |

## Verification
The bench exercises signed zeros, negative operands with reversed magnitude order, infinities, quiet versus signalling NaNs, and denormals with and without flushing, in both precisions.

Each corner case catches a specific fault:
- A design that compares raw bit patterns reports -0 as less than +0, or gets the order of two negative numbers backwards.
- A design that tests the wrong fraction bit mixes up the two kinds of NaN in quiet mode.
- A design that ignores `use_double` or `cmp_zero` lets the unused words leak into the result.

The bench also drives a clear in the same cycle as a new invalid compare. A design that gives the clear priority would then lose that event from the sticky flag.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int KEY_W = 63;

    typedef enum logic [1:0] {
        ORD_EQ,
        ORD_LT,
        ORD_GT,
        ORD_UN
    } ord_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } st_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             den;
        logic             zero;
        logic [KEY_W-1:0] mag;
    } opnd_t;

    // Fixed flag pattern {N,Z,C,V} for each ordering outcome
    function automatic logic [3:0] nzcv_of(ord_e o);
        logic [3:0] r;
        unique case (o)
            ORD_EQ:  r = 4'b0110;
            ORD_LT:  r = 4'b1000;
            ORD_GT:  r = 4'b0010;
            default: r = 4'b0011;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpcmp_class.sv
module fpcmp_class
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    input  logic                  ftz,
    output opnd_t                 info
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_max;
    logic              exp_zero;
    logic              frac_nz;
    logic              flush;

    always_comb begin
        expo     = word[W-2:FRAC_W];
        frac     = word[FRAC_W-1:0];
        exp_max  = &expo;
        exp_zero = ~|expo;
        frac_nz  = |frac;
        flush    = ftz & exp_zero & frac_nz;

        info.sign = word[W-1];
        info.nan  = exp_max & frac_nz;
        info.snan = exp_max & frac_nz & ~frac[FRAC_W-1];
        info.den  = exp_zero & frac_nz;
        info.mag  = flush ? '0 : KEY_W'(word[W-2:0]);
        info.zero = (info.mag == '0);
    end
endmodule

// File: rtl/fpcmp_operand.sv
module fpcmp_operand
    import fpcmp_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int SGL_EXP_W  = 8,
    parameter int DBL_EXP_W  = 11
) (
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic              dbl,
    input  logic              ftz,
    output opnd_t             info
);
    localparam int SGL_FRAC_W = WORD_W - 1 - SGL_EXP_W;
    localparam int DBL_FRAC_W = 2 * WORD_W - 1 - DBL_EXP_W;

    opnd_t sgl_info;
    opnd_t dbl_info;

    fpcmp_class #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_sgl (
        .word (lo),
        .ftz  (ftz),
        .info (sgl_info)
    );

    fpcmp_class #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_dbl (
        .word ({hi, lo}),
        .ftz  (ftz),
        .info (dbl_info)
    );

    assign info = dbl ? dbl_info : sgl_info;
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    output ord_e  ord
);
    always_comb begin
        if (a.nan || b.nan) begin
            ord = ORD_UN;
        end else if (a.zero && b.zero) begin
            ord = ORD_EQ;
        end else if (a.sign != b.sign) begin
            ord = a.sign ? ORD_LT : ORD_GT;
        end else if (a.mag == b.mag) begin
            ord = ORD_EQ;
        end else if ((a.mag < b.mag) ^ a.sign) begin
            ord = ORD_LT;
        end else begin
            ord = ORD_GT;
        end
    end
endmodule

// File: rtl/fpcmp_flag_unit.sv
module fpcmp_flag_unit
    import fpcmp_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int SGL_EXP_W = 8,
    parameter int DBL_EXP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              use_double,
    input  logic              cmp_zero,
    input  logic              signal_cmp,
    input  logic              ftz_en,
    input  logic [WORD_W-1:0] a_lo,
    input  logic [WORD_W-1:0] a_hi,
    input  logic [WORD_W-1:0] b_lo,
    input  logic [WORD_W-1:0] b_hi,
    input  logic              inv_clr,
    output logic              out_valid,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              inv_now,
    output logic              inv_sticky,
    output logic              dnm_now
);
    localparam int N_OPND = 2;

    logic [WORD_W-1:0] lane_lo [N_OPND];
    logic [WORD_W-1:0] lane_hi [N_OPND];
    opnd_t             lane_info [N_OPND];

    // Operand B becomes +0.0 in compare-against-zero mode
    always_comb begin
        lane_lo[0] = a_lo;
        lane_hi[0] = a_hi;
        lane_lo[1] = cmp_zero ? '0 : b_lo;
        lane_hi[1] = cmp_zero ? '0 : b_hi;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_lane
        fpcmp_operand #(
            .WORD_W    (WORD_W),
            .SGL_EXP_W (SGL_EXP_W),
            .DBL_EXP_W (DBL_EXP_W)
        ) u_opnd (
            .lo   (lane_lo[g]),
            .hi   (lane_hi[g]),
            .dbl  (use_double),
            .ftz  (ftz_en),
            .info (lane_info[g])
        );
    end

    ord_e ord;

    fpcmp_order u_order (
        .a   (lane_info[0]),
        .b   (lane_info[1]),
        .ord (ord)
    );

    logic inv_next;
    logic dnm_next;

    always_comb begin
        if (signal_cmp) begin
            inv_next = (ord == ORD_UN);
        end else begin
            inv_next = lane_info[0].snan | lane_info[1].snan;
        end
        dnm_next = ftz_en & (lane_info[0].den | lane_info[1].den);
    end

    // State register
    st_e state_q;
    st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_SHOW;
            ST_SHOW: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    logic [3:0] nzcv_q;
    logic       inv_q;
    logic       dnm_q;
    logic       sticky_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nzcv_q   <= '0;
            inv_q    <= 1'b0;
            dnm_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            if (in_valid) begin
                nzcv_q <= nzcv_of(ord);
                inv_q  <= inv_next;
                dnm_q  <= dnm_next;
            end
            sticky_q <= (inv_clr ? 1'b0 : sticky_q) | (in_valid & inv_next);
        end
    end

    assign out_valid  = (state_q == ST_SHOW);
    assign flag_n     = nzcv_q[3];
    assign flag_z     = nzcv_q[2];
    assign flag_c     = nzcv_q[1];
    assign flag_v     = nzcv_q[0];
    assign inv_now    = inv_q;
    assign dnm_now    = dnm_q;
    assign inv_sticky = sticky_q;
endmodule

// File: rtl/fpcmp_flag_unit_chk.sv
module fpcmp_flag_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic signal_cmp,
    input logic inv_clr,
    input logic out_valid,
    input logic flag_n,
    input logic flag_z,
    input logic flag_c,
    input logic flag_v,
    input logic inv_now,
    input logic inv_sticky
);
    logic [3:0] nzcv;
    assign nzcv = {flag_n, flag_z, flag_c, flag_v};

    p_legal_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (nzcv == 4'b0110 || nzcv == 4'b1000 ||
                       nzcv == 4'b0010 || nzcv == 4'b0011));

    p_unordered_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v |-> (flag_c && !flag_z && !flag_n));

    p_inv_only_unordered_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_now |-> flag_v);

    p_sig_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_v && $past(signal_cmp)) |-> inv_now);

    p_sticky_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && inv_now) |-> inv_sticky);

    p_sticky_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inv_sticky) |-> $past(inv_clr));

    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(nzcv) && $stable(inv_now)));
endmodule

bind fpcmp_flag_unit fpcmp_flag_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .signal_cmp (signal_cmp),
    .inv_clr    (inv_clr),
    .out_valid  (out_valid),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .flag_v     (flag_v),
    .inv_now    (inv_now),
    .inv_sticky (inv_sticky)
);

// File: tb/fpcmp_flag_unit_tb_top.sv
`timescale 1ns/1ps
module fpcmp_flag_unit_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, use_double = 1'b0, cmp_zero = 1'b0;
    logic        signal_cmp = 1'b0, ftz_en = 1'b0, inv_clr = 1'b0;
    logic [31:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
    logic        out_valid, flag_n, flag_z, flag_c, flag_v;
    logic        inv_now, inv_sticky, dnm_now;

    fpcmp_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_double(use_double),
        .cmp_zero(cmp_zero), .signal_cmp(signal_cmp), .ftz_en(ftz_en),
        .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi), .inv_clr(inv_clr),
        .out_valid(out_valid), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .flag_v(flag_v), .inv_now(inv_now), .inv_sticky(inv_sticky), .dnm_now(dnm_now)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    task automatic chk(string what, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural value of an encoding, computed arithmetically
    function automatic real fp_val(input logic [63:0] w, input bit dbl, input bit ftz,
                                   output bit isnan, output bit issnan, output bit isden);
        int          e;
        longint      f;
        real         r;
        if (dbl) begin
            e = int'(w[62:52]);
            f = longint'(w[51:0]);
            isnan  = (e == 2047) && (f != 0);
            issnan = isnan && (w[51] == 1'b0);
            isden  = (e == 0) && (f != 0);
            if (isnan || (isden && ftz)) r = 0.0;
            else                          r = $bitstoreal(w);
        end else begin
            e = int'(w[30:23]);
            f = longint'(w[22:0]);
            isnan  = (e == 255) && (f != 0);
            issnan = isnan && (w[22] == 1'b0);
            isden  = (e == 0) && (f != 0);
            if (e == 255)      r = $bitstoreal(64'h7FF0000000000000);
            else if (e == 0)   r = ftz ? 0.0 : real'(f) * (2.0 ** (-149));
            else               r = (1.0 + real'(f) / 8388608.0) * (2.0 ** (e - 127));
            if (w[31]) r = -r;
        end
        return r;
    endfunction

    // Reference model, updated on every rising edge
    logic [3:0] e_nzcv;
    logic       e_vld, e_inv, e_sticky, e_dnm;
    string      e_tag, e_itag;
    logic [63:0] wa, wb;
    real        ra, rb;
    bit         na, sna, da, nb, snb, db, ri;
    logic [3:0] onz;
    string      t;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_vld <= 0; e_nzcv <= 0; e_inv <= 0; e_sticky <= 0; e_dnm <= 0;
            e_tag <= "R12"; e_itag <= "R12";
        end else begin
            ri = 0;
            e_vld <= in_valid;
            if (in_valid) begin
                wa = use_double ? {a_hi, a_lo} : {32'b0, a_lo};
                wb = cmp_zero ? 64'd0 : (use_double ? {b_hi, b_lo} : {32'b0, b_lo});
                ra = fp_val(wa, use_double, ftz_en, na, sna, da);
                rb = fp_val(wb, use_double, ftz_en, nb, snb, db);
                if (na || nb)      begin onz = 4'b0011; t = "R4"; end
                else if (ra == rb) begin onz = 4'b0110; t = "R1"; end
                else if (ra < rb)  begin onz = 4'b1000; t = "R2"; end
                else               begin onz = 4'b0010; t = "R3"; end
                if (cmp_zero) t = {t, " R7"};
                if (ftz_en)   t = {t, " R8"};
                if (!na && !nb && ra == 0.0 && rb == 0.0) t = {t, " R9"};
                t = {t, " R10"};
                ri = signal_cmp ? (na || nb) : (sna || snb);
                e_nzcv <= onz;
                e_inv  <= ri;
                e_dnm  <= ftz_en && (da || db);
                e_tag  <= t;
                e_itag <= signal_cmp ? "R6" : "R5";
            end
            e_sticky <= (inv_clr ? 1'b0 : e_sticky) | ri;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("out_valid", "R12", {7'b0, out_valid}, {7'b0, e_vld});
            chk("nzcv", e_tag, {4'b0, flag_n, flag_z, flag_c, flag_v}, {4'b0, e_nzcv});
            chk("invalid", e_itag, {7'b0, inv_now}, {7'b0, e_inv});
            chk("sticky", "R11", {7'b0, inv_sticky}, {7'b0, e_sticky});
            chk("denormal", "R13", {7'b0, dnm_now}, {7'b0, e_dnm});
        end
    end

    task automatic op(bit dbl, bit z, bit sg, bit fz,
                      logic [31:0] alo, logic [31:0] ahi,
                      logic [31:0] blo, logic [31:0] bhi, bit clr);
        in_valid = 1; use_double = dbl; cmp_zero = z; signal_cmp = sg; ftz_en = fz;
        a_lo = alo; a_hi = ahi; b_lo = blo; b_hi = bhi; inv_clr = clr;
        @(negedge clk);
        in_valid = 0; inv_clr = 0;
    endtask

    task automatic idle(bit clr);
        in_valid = 0; inv_clr = clr;
        a_lo = $urandom; b_lo = $urandom;
        @(negedge clk);
        inv_clr = 0;
    endtask

    function automatic logic [31:0] pick_s();
        case ($urandom_range(0, 11))
            0: return 32'h00000000;  1: return 32'h80000000;
            2: return 32'h3F800000;  3: return 32'hBF800000;
            4: return 32'h00000001;  5: return 32'h807FFFFF;
            6: return 32'h7F800000;  7: return 32'hFF800000;
            8: return 32'h7FC00000;  9: return 32'h7F800001;
            10: return 32'hFFA00000;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [63:0] pick_d();
        case ($urandom_range(0, 11))
            0: return 64'h0;                     1: return 64'h8000000000000000;
            2: return 64'h3FF0000000000000;      3: return 64'hBFF0000000000000;
            4: return 64'h0000000000000001;      5: return 64'h800FFFFFFFFFFFFF;
            6: return 64'h7FF0000000000000;      7: return 64'hFFF0000000000000;
            8: return 64'h7FF8000000000000;      9: return 64'h7FF0000000000001;
            10: return 64'hFFF4000000000000;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("reset outputs", "R12",
            {out_valid, flag_n, flag_z, flag_c, flag_v, inv_now, inv_sticky, dnm_now}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        op(0,0,0,0, 32'h3F800000, 0, 32'h3F800000, 0, 0);            // R1 equal
        op(0,0,0,0, 32'h3F800000, 0, 32'h40000000, 0, 0);            // R2 less
        op(0,0,0,0, 32'hBF800000, 0, 32'hC0000000, 0, 0);            // R3 negatives
        op(0,0,0,0, 32'h7FC00000, 0, 32'h3F800000, 0, 0);            // R4/R5 quiet NaN
        op(0,0,0,0, 32'h3F800000, 0, 32'h7F800001, 0, 0);            // R5 signalling NaN
        op(0,0,1,0, 32'h7FC00000, 0, 32'h3F800000, 0, 0);            // R6
        idle(1);
        op(0,0,0,0, 32'h80000000, 0, 32'h00000000, 0, 0);            // R9 signed zeros
        op(0,1,0,0, 32'hBF800000, 0, 32'h7F800001, 32'hFFFFFFFF, 0); // R7 B ignored
        op(0,0,0,1, 32'h00000001, 0, 32'h00000000, 0, 0);            // R8/R13 flush
        op(0,0,0,0, 32'h00000001, 0, 32'h00000000, 0, 0);            // R8 no flush
        op(1,0,0,0, 32'h0, 32'h3FF80000, 32'h0, 32'h3FF00000, 0);    // R10 double
        op(0,0,0,0, 32'h3F800000, 32'h7FF80000, 32'h3F800000, 32'h0, 0); // R10 hi ignored
        op(1,0,0,0, 32'h00000001, 32'h7FF00000, 32'h0, 32'h0, 0);    // R5 double sNaN
        idle(0); idle(0);                                            // R11 sticky holds, R12 hold
        op(0,0,0,0, 32'h7F800001, 0, 32'h0, 0, 1);                   // R11 clear vs new invalid
        idle(1); idle(0);
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] x;
            logic [63:0] y;
            bit dsel;
            dsel = 1'($urandom_range(0, 1));
            x = dsel ? pick_d() : {$urandom, pick_s()};
            y = dsel ? pick_d() : {$urandom, pick_s()};
            if ($urandom_range(0, 4) == 0) idle(1'($urandom_range(0, 1)));
            else op(dsel, ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), x[31:0], x[63:32], y[31:0], y[63:32],
                    ($urandom_range(0, 7) == 0));
        end
        idle(0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R12 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule